// File: doc/BRIEF.md
# Command Packet Framer for a 2D Raster Pipeline

This block sits between a FIFO of 32-bit command words and the engines that act on them. The first word of every packet carries an 8-bit opcode in bits 31:24. The framer works out from that opcode how many words belong to the packet and collects them in a local buffer. Only when the packet is whole does it hand the packet on, one word per cycle, with a last flag on the final word. Drawing packets go to the rasterizer port. Block-copy and image-transfer headers go to the transfer port, tagged with a kind code.

Two polyline families have no fixed length. Their packets close on a sentinel word: any word that equals 0x5000_5000 once masked with 0xF000_F000, checked only at certain word positions. Settings words (opcodes 0xE0 to 0xE7) are not forwarded. Each one is written whole into one of eight settings registers. The low 13 bits of a status word follow two of those registers. After an image-write header has been sent, later input words skip decoding and stream straight to the transfer port until the transfer engine pulses its completion input.

Top module: `gpu_cmd_framer`

## Requirements
- R1: After reset, settings register i reads ((0xE0 + i) << 24), status reads 0x1480_2000, `err` is 0, neither output valid is high and `in_ready` is 1.
- R2: Fixed-length drawing opcodes produce packets of this many total words on the rasterizer port, with `out_kind` = 0 and `out_last` only on the final word: 0x00 and 0x01 give 1; 0x02 gives 3; 0x20-23 give 4; 0x24-27 give 7; 0x28-2B give 5; 0x2C-2F give 9; 0x30-33 give 6; 0x34-37 give 9; 0x38-3B give 8; 0x3C-3F give 12; 0x40-47 give 3; 0x50-57 give 4; 0x60-63 give 3; 0x64-67 give 4; 0x68-6B give 2; 0x70-73 give 2; 0x74-77 give 3; 0x78-7B give 2; 0x7C-7F give 3.
- R3: No word of a packet appears on either output until the last word of that packet has been accepted. While a packet is being sent, `in_ready` is 0.
- R4: Opcodes 0x48-0x4F are flat polylines. Starting at word index 3, every word is tested, and the packet closes on and includes the first word w where (w & 0xF000_F000) == 0x5000_5000. A matching word at index 1 or 2 does not close it.
- R5: Opcodes 0x58-0x5F are shaded polylines. Only words at even indices 4, 6, 8, and so on are tested against the same sentinel pattern. A matching word at an odd index does not close the packet.
- R6: Opcodes 0x80-0x9F form 4-word packets on the transfer port with `out_kind` = 1.
- R7: Opcodes 0xA0-0xBF form 3-word packets on the transfer port with `out_kind` = 2. After such a packet, every accepted input word passes unchanged to the transfer port with `out_kind` = 4 and `out_last` = 0, and is not decoded, until `xfr_done` is high. Opcodes 0xC0-0xDF form 3-word packets with `out_kind` = 3 and start no bypass.
- R8: A word with opcode 0xE0-0xE7 is stored whole in settings register (opcode & 7) and produces no output word. Settings registers change only when such a word is accepted.
- R9: Status bits 10:0 follow settings register 1 bits 10:0 and status bits 12:11 follow settings register 6 bits 1:0, one cycle after the register changes. Bits 31:13 keep their reset value.
- R10: Any opcode not listed in R2 and R4-R8 is consumed as a single word, produces no output, and sets `err`, which stays set until reset.
- R11: While the selected output's ready is low, its valid stays high and `out_data` and `out_last` hold their values.
- R12: A polyline that reaches DEPTH words without a sentinel is closed at DEPTH words, with `out_last` on word DEPTH, and sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Command word from the FIFO |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Framer takes the word this cycle |
| out_data | output | 32 | Outgoing packet or bypass word |
| out_last | output | 1 | Final word of a packet |
| out_kind | output | 3 | 0 draw, 1 block copy, 2 image-write header, 3 image-read header, 4 image-write payload |
| ras_valid | output | 1 | Word offered to the rasterizer |
| ras_ready | input | 1 | Rasterizer takes the word |
| xfr_valid | output | 1 | Word offered to the transfer engine |
| xfr_ready | input | 1 | Transfer engine takes the word |
| xfr_done | input | 1 | Transfer engine has finished an image write |
| cfg_regs | output | 256 | Eight settings registers, register i in bits 32*i+31:32*i |
| status | output | 32 | Status word |
| err | output | 1 | Sticky error flag |

## Verification
The bench goes after the edges of length detection. It places sentinel-shaped words at the positions that must be ignored: indices 1 and 2 of a flat polyline and an odd index of a shaded one. A framer that tests too early, or at every index, would close those packets short. Settings-shaped words are fed during an image-write bypass. A framer that kept decoding there would overwrite a settings register and lose payload words. Packets are held back by a stalled output, an unknown opcode is followed by a valid one, and a polyline runs past its buffer. These show up a design that drops or duplicates words under backpressure, swallows the word after an unknown opcode, or never closes an endless polyline.

// File: rtl/gpu_cmd_framer.sv
module gpu_cmd_framer #(
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [31:0]  out_data,
  output logic         out_last,
  output logic [2:0]   out_kind,
  output logic         ras_valid,
  input  logic         ras_ready,
  output logic         xfr_valid,
  input  logic         xfr_ready,
  input  logic         xfr_done,
  output logic [255:0] cfg_regs,
  output logic [31:0]  status,
  output logic         err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LASTI = (AW+1)'(DEPTH - 1);
  localparam logic [AW:0] IDX3  = (AW+1)'(3);
  localparam logic [AW:0] IDX4  = (AW+1)'(4);
  localparam logic [31:0] STAT_RST = 32'h1480_2000;
  localparam logic [2:0] K_DRAW = 3'd0, K_COPY = 3'd1, K_WRH = 3'd2, K_RDH = 3'd3, K_WRD = 3'd4;

  typedef enum logic [1:0] {S_COL, S_EMIT, S_XFER} state_t;

  state_t      state;
  logic [AW:0] cnt, need, plen, eidx;
  logic [1:0]  poly;
  logic [2:0]  kind;
  logic [31:0] cfg [8];
  logic [12:0] stat_lo;
  logic [31:0] pbuf [DEPTH];

  logic [4:0]  d_len;
  logic [1:0]  d_poly;
  logic [2:0]  d_kind;
  logic        d_set, d_bad;

  always_comb begin
    d_len = 5'd1; d_poly = 2'd0; d_kind = K_DRAW; d_set = 1'b0; d_bad = 1'b0;
    case (in_data[31:24]) inside
      8'h00, 8'h01:  d_len = 5'd1;
      8'h02:         d_len = 5'd3;
      [8'h20:8'h23]: d_len = 5'd4;
      [8'h24:8'h27]: d_len = 5'd7;
      [8'h28:8'h2B]: d_len = 5'd5;
      [8'h2C:8'h2F]: d_len = 5'd9;
      [8'h30:8'h33]: d_len = 5'd6;
      [8'h34:8'h37]: d_len = 5'd9;
      [8'h38:8'h3B]: d_len = 5'd8;
      [8'h3C:8'h3F]: d_len = 5'd12;
      [8'h40:8'h47]: d_len = 5'd3;
      [8'h48:8'h4F]: d_poly = 2'd1;
      [8'h50:8'h57]: d_len = 5'd4;
      [8'h58:8'h5F]: d_poly = 2'd2;
      [8'h60:8'h63]: d_len = 5'd3;
      [8'h64:8'h67]: d_len = 5'd4;
      [8'h68:8'h6B]: d_len = 5'd2;
      [8'h70:8'h73]: d_len = 5'd2;
      [8'h74:8'h77]: d_len = 5'd3;
      [8'h78:8'h7B]: d_len = 5'd2;
      [8'h7C:8'h7F]: d_len = 5'd3;
      [8'h80:8'h9F]: begin d_len = 5'd4; d_kind = K_COPY; end
      [8'hA0:8'hBF]: begin d_len = 5'd3; d_kind = K_WRH; end
      [8'hC0:8'hDF]: begin d_len = 5'd3; d_kind = K_RDH; end
      [8'hE0:8'hE7]: d_set = 1'b1;
      default:       d_bad = 1'b1;
    endcase
  end

  wire         acc      = in_valid && in_ready;
  wire         first    = (cnt == '0);
  wire [AW:0]  cur_need = first ? (AW+1)'(d_len) : need;
  wire [1:0]   cur_poly = first ? d_poly : poly;
  wire [2:0]   cur_kind = first ? d_kind : kind;
  wire         sentinel = (in_data & 32'hF000_F000) == 32'h5000_5000;
  wire         poly_hit = sentinel && ((cur_poly == 2'd1 && cnt >= IDX3) ||
                                       (cur_poly == 2'd2 && cnt >= IDX4 && !cnt[0]));
  wire         full     = (cnt == LASTI);
  wire         pkt_end  = (first && (d_set || d_bad)) ||
                          ((cur_poly == 2'd0) ? (cnt + 1'b1 == cur_need) : (poly_hit || full));

  assign in_ready  = (state == S_COL) || (state == S_XFER && xfr_ready);
  assign ras_valid = (state == S_EMIT) && (kind == K_DRAW);
  assign xfr_valid = ((state == S_EMIT) && (kind != K_DRAW)) || ((state == S_XFER) && in_valid);
  assign out_data  = (state == S_XFER) ? in_data : pbuf[eidx[AW-1:0]];
  assign out_last  = (state == S_EMIT) && (eidx == plen - 1'b1);
  assign out_kind  = (state == S_XFER) ? K_WRD : kind;
  wire   fire      = (ras_valid && ras_ready) || (xfr_valid && xfr_ready);

  assign status = {STAT_RST[31:13], stat_lo};

  for (genvar g = 0; g < 8; g++) begin : g_cfg
    assign cfg_regs[g*32 +: 32] = cfg[g];
  end

  always_ff @(posedge clk)
    if (acc && state == S_COL) pbuf[cnt[AW-1:0]] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_COL; cnt <= '0; need <= '0; plen <= '0; eidx <= '0;
      poly <= '0; kind <= K_DRAW; err <= 1'b0; stat_lo <= '0;
      for (int i = 0; i < 8; i++) cfg[i] <= {8'hE0 | 8'(i), 24'h0};
    end else begin
      stat_lo <= {cfg[6][1:0], cfg[1][10:0]};
      case (state)
        S_COL: if (acc) begin
          need <= cur_need; poly <= cur_poly; kind <= cur_kind;
          if (pkt_end) begin
            cnt <= '0;
            if (first && d_set) cfg[in_data[26:24]] <= in_data;
            else if (first && d_bad) err <= 1'b1;
            else begin
              plen  <= cnt + 1'b1;
              eidx  <= '0;
              state <= S_EMIT;
              if (cur_poly != 2'd0 && !poly_hit) err <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_EMIT: if (fire) begin
          if (out_last) state <= (kind == K_WRH) ? S_XFER : S_COL;
          else eidx <= eidx + 1'b1;
        end
        S_XFER: if (xfr_done) state <= S_COL;
        default: state <= S_COL;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) $rose(rst_n) |-> !ras_valid && !xfr_valid && !err && in_ready);
  a_r3_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_valid || (xfr_valid && out_kind != K_WRD)) |-> !in_ready);
  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_n) !(ras_valid && xfr_valid));
  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ras_valid && ras_ready && out_last |=> !ras_valid);
  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_COL) |=> $stable(cfg_regs));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  a_r11_ras_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ras_valid && !ras_ready |=> ras_valid && $stable(out_data) && $stable(out_last));
  a_r11_xfr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfr_valid && !xfr_ready && out_kind != K_WRD |=> xfr_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: tb/sim_gpu_cmd_framer.sv
`timescale 1ns/1ps
module sim_gpu_cmd_framer;
  localparam int DEPTH = 32;
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {8'h02, 5'd3, 3'd0}, {8'h20, 5'd4, 3'd0}, {8'h25, 5'd7, 3'd0}, {8'h2A, 5'd5, 3'd0},
    {8'h2F, 5'd9, 3'd0}, {8'h31, 5'd6, 3'd0}, {8'h34, 5'd9, 3'd0}, {8'h3B, 5'd8, 3'd0},
    {8'h3C, 5'd12, 3'd0}, {8'h46, 5'd3, 3'd0}, {8'h50, 5'd4, 3'd0}, {8'h62, 5'd3, 3'd0},
    {8'h65, 5'd4, 3'd0}, {8'h68, 5'd2, 3'd0}, {8'h71, 5'd2, 3'd0}, {8'h77, 5'd3, 3'd0},
    {8'h78, 5'd2, 3'd0}, {8'h7E, 5'd3, 3'd0}, {8'h00, 5'd1, 3'd0}, {8'h9C, 5'd4, 3'd1},
    {8'hC3, 5'd3, 3'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0]  in_data = '0, out_data;
  logic         in_valid = 1'b0, in_ready, out_last, ras_valid, xfr_valid, err;
  logic         ras_ready = 1'b1, xfr_ready = 1'b1, xfr_done = 1'b0;
  logic [2:0]   out_kind;
  logic [255:0] cfg_regs;
  logic [31:0]  status;

  gpu_cmd_framer #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_last(out_last), .out_kind(out_kind),
    .ras_valid(ras_valid), .ras_ready(ras_ready), .xfr_valid(xfr_valid), .xfr_ready(xfr_ready),
    .xfr_done(xfr_done), .cfg_regs(cfg_regs), .status(status), .err(err));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] cap_data [1024];
  logic        cap_last [1024];
  logic [2:0]  cap_kind [1024];
  logic        cap_path [1024];
  int          cap_n = 0;
  logic [31:0] pw [64];

  always @(negedge clk) begin
    #1;
    if (rst_n && ((ras_valid && ras_ready) || (xfr_valid && xfr_ready)) && cap_n < 1024) begin
      cap_data[cap_n] <= out_data;
      cap_last[cap_n] <= out_last;
      cap_kind[cap_n] <= out_kind;
      cap_path[cap_n] <= xfr_valid;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send(pw[i]);
  endtask

  task automatic chk_pkt(input string req, input int base, input int len, input logic [2:0] kind,
                         input bit path, input logic [31:0] w0);
    bit ok = (cap_n - base == len) && (cap_data[base] == w0);
    for (int i = 0; i < len; i++)
      ok &= (cap_last[base+i] == (i == len-1)) && (cap_kind[base+i] == kind) && (cap_path[base+i] == path);
    chk(ok, req, 32'(cap_n - base), 32'(len));
  endtask

  task automatic do_reset();
    in_valid = 1'b0; rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic chk_reset();
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++) ok &= (cfg_regs[i*32 +: 32] == {8'hE0 + 8'(i), 24'h0});
    chk(ok, "R1 settings", cfg_regs[63:32], 32'hE100_0000);
    chk(status == 32'h1480_2000, "R1 status", status, 32'h1480_2000);
    chk(!err && !ras_valid && !xfr_valid && in_ready, "R1 flags",
        {28'h0, err, ras_valid, xfr_valid, in_ready}, 32'h1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  int base, len;
  logic [7:0] op;
  logic [2:0] kind;
  logic [31:0] held;

  initial begin
    @(negedge clk);
    do_reset();
    chk_reset();

    for (int v = 0; v < NV; v++) begin
      op = VEC[v][15:8]; len = int'(VEC[v][7:3]); kind = VEC[v][2:0];
      pw[0] = {op, 24'h00_0100};
      for (int i = 1; i < len; i++) pw[i] = 32'h0002_0000 + 32'(i);
      base = cap_n;
      send_n(len - 1);
      if (len > 1) begin
        wait_n(3);
        chk(cap_n == base, "R3 early issue", 32'(cap_n - base), 32'h0);
      end
      send(pw[len-1]);
      wait_n(len + 4);
      chk_pkt(kind == 3'd1 ? "R6" : (kind == 3'd3 ? "R7 read" : "R2"), base, len, kind, kind != 3'd0, pw[0]);
    end

    // R4 flat polyline, sentinel-shaped words at indices 1 and 2 ignored
    pw[0] = 32'h4800_0100; pw[1] = 32'h5000_5000; pw[2] = 32'h5F00_5A00;
    pw[3] = 32'h1234_5678; pw[4] = 32'h5A00_5F00; pw[5] = 32'h0000_0000;
    base = cap_n; send_n(5); wait_n(9);
    chk_pkt("R4", base, 5, 3'd0, 1'b0, 32'h4800_0100);
    chk(cap_data[base+4] == 32'h5A00_5F00, "R4 sentinel word", cap_data[base+4], 32'h5A00_5F00);

    // R5 shaded polyline, odd-index sentinel ignored
    pw[0] = 32'h5A00_0100; pw[1] = 32'h0000_0001; pw[2] = 32'h0000_0002; pw[3] = 32'h0000_0003;
    pw[4] = 32'h0000_1111; pw[5] = 32'h5000_5000; pw[6] = 32'h5555_5555;
    base = cap_n; send_n(7); wait_n(11);
    chk_pkt("R5", base, 7, 3'd0, 1'b0, 32'h5A00_0100);

    // R7 image write header then bypass
    pw[0] = 32'hA000_0000; pw[1] = 32'h0004_0010; pw[2] = 32'h0001_0002;
    base = cap_n; send_n(3); wait_n(7);
    chk_pkt("R7 header", base, 3, 3'd2, 1'b1, 32'hA000_0000);
    base = cap_n;
    send(32'hE100_00FF); send(32'h1234_5678); wait_n(3);
    chk((cap_n - base == 2) && cap_kind[base] == 3'd4 && cap_kind[base+1] == 3'd4 &&
        !cap_last[base] && !cap_last[base+1] && cap_path[base] &&
        cap_data[base] == 32'hE100_00FF && cap_data[base+1] == 32'h1234_5678,
        "R7 bypass", 32'(cap_n - base), 32'h2);
    chk(cfg_regs[63:32] == 32'hE100_0000, "R7 bypass not decoded", cfg_regs[63:32], 32'hE100_0000);
    xfr_done = 1'b1; @(negedge clk); xfr_done = 1'b0;
    base = cap_n; send(32'h0100_0000); wait_n(4);
    chk_pkt("R7 resume", base, 1, 3'd0, 1'b0, 32'h0100_0000);

    // R8 settings capture
    base = cap_n; send(32'hE30A_BCDE); wait_n(3);
    chk(cfg_regs[127:96] == 32'hE30A_BCDE && cap_n == base, "R8", cfg_regs[127:96], 32'hE30A_BCDE);

    // R9 status tracking
    send(32'hE100_07FF); send(32'hE600_0003); wait_n(3);
    chk(status == 32'h1480_3FFF, "R9 all set", status, 32'h1480_3FFF);
    send(32'hE100_0123); wait_n(3);
    chk(status == 32'h1480_3923, "R9 update", status, 32'h1480_3923);

    // R11 backpressure
    ras_ready = 1'b0;
    pw[0] = 32'h4000_0100; pw[1] = 32'h0000_0002; pw[2] = 32'h0000_0003;
    base = cap_n; send_n(3); wait_n(3);
    held = out_data;
    chk(ras_valid && held == 32'h4000_0100, "R11 offered", held, 32'h4000_0100);
    wait_n(4);
    chk(ras_valid && out_data == held && !out_last, "R11 held", out_data, held);
    ras_ready = 1'b1; wait_n(6);
    chk_pkt("R11 drained", base, 3, 3'd0, 1'b0, 32'h4000_0100);

    // R10 unknown opcode
    base = cap_n; send(32'h1000_0000); wait_n(3);
    chk(err && cap_n == base, "R10 dropped", {31'h0, err}, 32'h1);
    send(32'h0100_0000); wait_n(4);
    chk_pkt("R10 next word kept", base, 1, 3'd0, 1'b0, 32'h0100_0000);

    // reset clears err, then R12 overflow
    do_reset();
    chk_reset();
    pw[0] = 32'h4800_0100;
    for (int i = 1; i < DEPTH; i++) pw[i] = 32'h0003_0000 + 32'(i);
    base = cap_n; send_n(DEPTH); wait_n(DEPTH + 6);
    chk_pkt("R12", base, DEPTH, 3'd0, 1'b0, 32'h4800_0100);
    chk(err, "R12 err", {31'h0, err}, 32'h1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule